// File: doc/BRIEF.md
# Decode-Stage Next-PC and Branch Resolve

This block holds the program counter of a five-stage pipeline as a word address and chooses, while a control-flow instruction sits in decode, where fetch goes next. Because branches resolve in decode, a taken branch or jump costs one delay cycle. Exactly one wrongly fetched successor is squashed, and a not-taken branch lets that successor run (predict not taken).

The branch decision does not use the execute-stage ALU. The block compares the two forwarded register operands for equality itself. Branch targets are formed from the incremented PC carried with the decoded instruction plus a sign-extended word offset. Jump targets splice a 26-bit word index under the top four bits of that incremented PC.

The redirect output loads the PC with the target and also clears the fetch/decode pipeline register on the next edge, which turns the fetched successor into a no-op. A stall input freezes the PC. A redirect overrides the stall's hold of the fetch/decode register.

Top module: `decode_next_pc`

## Requirements
- R1: While `rst_n` is low, `pc_q` is word address 0.
- R2: With none of `is_beq`, `is_bne`, `is_jmp` set, `redirect` is 0 and `next_pc` equals `pc_q + 1`, wrapping modulo 2^30.
- R3: With `is_beq` set and `opnd_a == opnd_b`, `redirect` is 1 and `next_pc` equals `inc_pc` plus `br_imm` sign-extended from bit 15 (a word offset, i.e. four times the value in bytes), modulo 2^30.
- R4: With `is_bne` set and `opnd_a != opnd_b`, `redirect` is 1 and `next_pc` is the same branch target as in R3.
- R5: With `is_jmp` set, `redirect` is 1 regardless of the operands, and `next_pc` is `{inc_pc[29:26], jmp_imm}`.
- R6: A branch whose condition fails (beq with unequal operands, bne with equal operands) gives `redirect` 0 and `next_pc = pc_q + 1`.
- R7: On each rising edge with `rst_n` high and `hold` low, `pc_q` takes the `next_pc` value present before that edge.
- R8: On a rising edge with `hold` high, `pc_q` keeps its value. `ifid_keep` equals `hold` and not `redirect`, so a redirect (the fetch/decode clear) wins over the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Stall: keep the PC and the fetch/decode register |
| inc_pc | input | 30 | Incremented word PC of the instruction in decode |
| br_imm | input | 16 | Branch word offset, two's complement |
| jmp_imm | input | 26 | Jump word index |
| is_beq | input | 1 | Decoded branch-if-equal |
| is_bne | input | 1 | Decoded branch-if-not-equal |
| is_jmp | input | 1 | Decoded unconditional jump |
| opnd_a | input | 32 | First forwarded register value |
| opnd_b | input | 32 | Second forwarded register value |
| pc_q | output | 30 | Current fetch word address |
| next_pc | output | 30 | Word address fetched after this cycle |
| redirect | output | 1 | Taken control flow; clears fetch/decode on the next edge |
| ifid_keep | output | 1 | Hold enable for the fetch/decode register |

## Verification
`redirect`, `next_pc` and `ifid_keep` are combinational and are due in the same cycle as the decode inputs. The bench drives the inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. `pc_q` is due one rising edge after the inputs, so the bench updates its model of the PC at that edge and compares at the following falling edge. Random operand pairs are forced equal half the time so that both branch senses are covered. Directed cases cover negative and extreme offsets and the wrap of the PC from all ones to zero.

// File: rtl/decode_next_pc.sv
module decode_next_pc #(
  parameter int AW  = 30,
  parameter int BIW = 16,
  parameter int JIW = 26,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [AW-1:0] inc_pc,
  input  logic [BIW-1:0] br_imm,
  input  logic [JIW-1:0] jmp_imm,
  input  logic          is_beq,
  input  logic          is_bne,
  input  logic          is_jmp,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          ifid_keep
);
  localparam int SX = AW - BIW;

  logic          ops_eq, take_br;
  logic [AW-1:0] br_tgt, j_tgt, fall;

  assign ops_eq   = (opnd_a == opnd_b);
  assign take_br  = (is_beq & ops_eq) | (is_bne & ~ops_eq);
  assign redirect = is_jmp | take_br;

  assign br_tgt = inc_pc + {{SX{br_imm[BIW-1]}}, br_imm};
  assign j_tgt  = {inc_pc[AW-1:JIW], jmp_imm};
  assign fall   = pc_q + AW'(1);

  assign next_pc   = is_jmp ? j_tgt : (take_br ? br_tgt : fall);
  assign ifid_keep = hold & ~redirect;

  always_ff @(posedge clk) begin
    if (!rst_n)     pc_q <= '0;
    else if (!hold) pc_q <= next_pc;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> pc_q == '0);
  p_idle_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_beq | is_bne | is_jmp) |-> !redirect);
  p_jump_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_jmp |-> redirect);
  p_load_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !hold) |=> pc_q == $past(next_pc));
  p_hold_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && hold) |=> $stable(pc_q));
  p_flush_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !ifid_keep);
endmodule

// File: tb/test_decode_next_pc.sv
`timescale 1ns/1ps
module test_decode_next_pc;
  logic        clk = 0, rst_n = 0, hold = 0;
  logic [29:0] inc_pc = '0;
  logic [15:0] br_imm = '0;
  logic [25:0] jmp_imm = '0;
  logic        is_beq = 0, is_bne = 0, is_jmp = 0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [29:0] pc_q, next_pc;
  logic        redirect, ifid_keep;
  int checks = 0, fails = 0;
  logic [29:0] m_pc;

  always #2.5 clk = ~clk;

  decode_next_pc i_decode_next_pc (.*);

  function automatic logic [29:0] f_btgt(logic [29:0] i, logic [15:0] o);
    return i + {{14{o[15]}}, o};
  endfunction

  function automatic logic f_take(logic b, logic n, logic j, logic [31:0] a, logic [31:0] c);
    return j | (b & (a == c)) | (n & (a != c));
  endfunction

  function automatic logic [29:0] f_next(logic [29:0] pc, logic [29:0] i, logic [15:0] o,
      logic [25:0] ji, logic b, logic n, logic j, logic [31:0] a, logic [31:0] c);
    if (j) return {i[29:26], ji};
    if (f_take(b, n, 0, a, c)) return f_btgt(i, o);
    return pc + 30'd1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic b, logic n, logic j, logic tk);
    if (j) return "R5";
    if (b && tk) return "R3";
    if (n && tk) return "R4";
    if (b || n) return "R6";
    return "R2";
  endfunction

  // Drives at the falling edge, checks combinational outputs, then the PC after the edge.
  task automatic step(logic h, logic [29:0] i, logic [15:0] o, logic [25:0] ji,
                      logic b, logic n, logic j, logic [31:0] a, logic [31:0] c);
    logic tk;
    logic [29:0] nx;
    hold = h; inc_pc = i; br_imm = o; jmp_imm = ji;
    is_beq = b; is_bne = n; is_jmp = j; opnd_a = a; opnd_b = c;
    #1;
    tk = f_take(b, n, j, a, c);
    nx = f_next(m_pc, i, o, ji, b, n, j, a, c);
    chk(tag_of(b, n, j, tk), {31'd0, redirect}, {31'd0, tk});
    chk(tag_of(b, n, j, tk), {2'd0, next_pc}, {2'd0, nx});
    chk("R8 ifid_keep", {31'd0, ifid_keep}, {31'd0, h & ~tk});
    @(posedge clk);
    if (!h) m_pc = nx;
    @(negedge clk);
    chk(h ? "R8 hold pc" : "R7 pc load", {2'd0, pc_q}, {2'd0, m_pc});
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_pc = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", {2'd0, pc_q}, 32'd0);
    rst_n = 1;
    // directed corner cases
    step(0, 30'h100, 16'h0000, 0, 0, 0, 0, 1, 2);            // R2 idle
    step(0, 30'h100, 16'hFFFF, 0, 1, 0, 0, 5, 5);            // R3 offset -1
    step(0, 30'h200, 16'h8000, 0, 1, 0, 0, 7, 7);            // R3 most negative
    step(0, 30'h200, 16'h7FFF, 0, 0, 1, 0, 7, 8);            // R4 most positive
    step(0, 30'h300, 16'h0010, 0, 0, 1, 0, 9, 9);            // R6 bne not taken
    step(0, 30'h300, 16'h0010, 0, 1, 0, 0, 9, 8);            // R6 beq not taken
    step(1, 30'h3C00_0000, 0, 26'h3FF_FFFF, 0, 0, 1, 0, 1);  // R8 hold with flush
    step(0, 30'h3C00_0000, 0, 26'h3FF_FFFF, 0, 0, 1, 0, 1);  // R5 jump to all ones
    step(0, 30'h0, 0, 0, 0, 0, 0, 0, 0);                     // R2 wrap to zero
    step(1, 30'h0, 0, 0, 0, 0, 0, 0, 0);                     // R8 hold, no flush
    rst_n = 0;
    @(posedge clk); m_pc = '0; @(negedge clk);
    chk("R1 reset again", {2'd0, pc_q}, 32'd0);
    rst_n = 1;
    for (int k = 0; k < 2000; k++) begin
      int kind;
      logic [31:0] a, c;
      kind = $urandom_range(0, 3);
      a = $urandom;
      c = ($urandom_range(0, 1) != 0) ? a : $urandom;
      step($urandom_range(0, 3) == 0, 30'($urandom), 16'($urandom), 26'($urandom),
           kind == 1, kind == 2, kind == 3, a, c);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule